// File: doc/BRIEF.md
# Instruction Fetch Realignment Queue

This block sits between the instruction memory interface and the decoder. The fetch side delivers 32-bit words, each tagged with its word address and an error flag. The block stores up to `DEPTH` such words (three by default) and presents one complete instruction per handshake to the decoder, together with the program counter of that instruction. Instructions are either 16 bits wide (compressed) or 32 bits wide, and they may begin on any half-word boundary. A 32-bit instruction that starts in the upper half of a word is therefore built from two consecutive words.

When the queue holds nothing, an arriving word passes straight through to the decoder in the cycle it arrives, so there is no lost cycle after a redirect. A clear input, driven whenever the program flow is redirected, discards everything held. The same cycle loads the half-word position of the new target. A full indication tells the fetch logic to stop offering words.

Top module: `fetch_realign_fifo`

## Requirements
- R1: After reset, `outValidO` and `fullO` are both low.
- R2: When the queue is empty, a word offered on the input is visible on the output (instruction, PC and error) in the same cycle, provided the instruction it starts is complete within that word.
- R3: A half-word whose bits [1:0] are not 2'b11 is a compressed instruction and is presented as `{16'h0000, half}`. A half-word with bits [1:0] equal to 2'b11 starts a 32-bit instruction.
- R4: `outPcO` equals `{word address, position bit, 1'b0}`. Bit 0 is always zero. After each accepted instruction, the next presented PC is 2 higher for a compressed instruction and 4 higher for a 32-bit one.
- R5: A 32-bit instruction starting at the upper half of a word is presented as `{next word[15:0], this word[31:16]}`. `outValidO` stays low until both words are present.
- R6: While `clearI` is high, `outValidO` is low and an offered word is not stored. After the clear, the queue is empty and the position bit equals `clearHalfSelI`.
- R7: `outErrO` is the OR of the error flags of every word that contributes bits to the presented instruction.
- R8: `fullO` is high exactly when `DEPTH` words are stored. A word offered while `fullO` is high is dropped.
- R9: While `outValidO` is high and `outReadyI` is low (and no clear arrives), the presented instruction, PC and error flag stay unchanged in the next cycle.
- R10: Instructions are delivered in fetch order, each exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| clearI | input | 1 | Discard all stored words (redirect) |
| clearHalfSelI | input | 1 | Bit 1 of the redirect target, loaded on clear |
| inValidI | input | 1 | A fetched word is offered |
| inDataI | input | 32 | Fetched word |
| inWordAddrI | input | ADDR_W-2 | Word address of the fetched word |
| inErrI | input | 1 | Fetch error for this word |
| fullO | output | 1 | All entries occupied; stop offering words |
| outValidO | output | 1 | A complete instruction is presented |
| outReadyI | input | 1 | Decoder accepts the presented instruction |
| outInstrO | output | 32 | Instruction, compressed ones zero-extended |
| outPcO | output | ADDR_W | PC of the presented instruction |
| outErrO | output | 1 | Error flag of the presented instruction |

## Verification
The scoreboard runs word streams that start aligned and streams that start on a half-word. The mix ranges from all compressed, through mixed, to all 32-bit. Together these separate the plain word path, the realignment path and the position-bit toggling. Random input gaps and decoder stalls of varying density vary the fill level. They decide whether words travel through the bypass, sit in storage, or pile up to the full limit, which exposes ordering and drop errors. Directed sequences target the same-cycle bypass, the wait for a second word, a word offered while full, and a clear that coincides with an offered word.

// File: rtl/frf_pkg.sv
package frf_pkg;
  localparam int INSTR_W = 32;
  localparam int HALF_W  = INSTR_W / 2;

  // Strobes from control to datapath
  typedef struct packed {
    logic store;   // write the offered word into the first free slot
    logic shift;   // drop the head slot, move the rest down
    logic flush;   // invalidate every slot
  } frfStrobe_t;

  function automatic logic isCompressed(input logic [HALF_W-1:0] half);
    return half[1:0] != 2'b11;
  endfunction
endpackage

// File: rtl/frf_datapath.sv
module frf_datapath
  import frf_pkg::*;
#(
  parameter int DEPTH  = 3,
  parameter int ADDR_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  frfStrobe_t         stb,
  input  logic               alignHi,
  input  logic [INSTR_W-1:0] inData,
  input  logic [ADDR_W-3:0]  inWordAddr,
  input  logic               inErr,
  output logic [1:0]         headVld,
  output logic               lastVld,
  output logic [INSTR_W-1:0] instr,
  output logic [ADDR_W-1:0]  pc,
  output logic               err,
  output logic               halfCmp
);
  localparam int WA_W = ADDR_W - 2;

  logic [INSTR_W-1:0] memData [DEPTH];
  logic [WA_W-1:0]    memAddr [DEPTH];
  logic [DEPTH-1:0]   memErr;
  logic [DEPTH-1:0]   vld;

  logic [INSTR_W-1:0] shData [DEPTH];
  logic [WA_W-1:0]    shAddr [DEPTH];
  logic [DEPTH-1:0]   shErr;
  logic [DEPTH-1:0]   shVld;
  logic [DEPTH-1:0]   wrSel;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    if (i < DEPTH - 1) begin : g_mid
      assign shData[i] = stb.shift ? memData[i+1] : memData[i];
      assign shAddr[i] = stb.shift ? memAddr[i+1] : memAddr[i];
      assign shErr[i]  = stb.shift ? memErr[i+1]  : memErr[i];
      assign shVld[i]  = stb.shift ? vld[i+1]     : vld[i];
    end else begin : g_last
      assign shData[i] = memData[i];
      assign shAddr[i] = memAddr[i];
      assign shErr[i]  = memErr[i];
      assign shVld[i]  = stb.shift ? 1'b0 : vld[i];
    end
    // valid bits form a thermometer, so the first free slot follows the last used one
    if (i == 0) begin : g_first
      assign wrSel[i] = !shVld[i];
    end else begin : g_next
      assign wrSel[i] = !shVld[i] && shVld[i-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vld <= '0;
    end else if (stb.flush) begin
      vld <= '0;
    end else begin
      vld <= shVld | ({DEPTH{stb.store}} & wrSel);
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < DEPTH; k++) begin
      if (stb.store && wrSel[k]) begin
        memData[k] <= inData;
        memAddr[k] <= inWordAddr;
        memErr[k]  <= inErr;
      end else begin
        memData[k] <= shData[k];
        memAddr[k] <= shAddr[k];
        memErr[k]  <= shErr[k];
      end
    end
  end

  // head words: stored if present, otherwise the word on the input
  logic [INSTR_W-1:0] w0Data, w1Data;
  logic [WA_W-1:0]    w0Addr;
  logic               w0Err, w1Err;
  logic [HALF_W-1:0]  curHalf;

  assign w0Data = vld[0] ? memData[0] : inData;
  assign w0Addr = vld[0] ? memAddr[0] : inWordAddr;
  assign w0Err  = vld[0] ? memErr[0]  : inErr;
  assign w1Data = vld[1] ? memData[1] : inData;
  assign w1Err  = vld[1] ? memErr[1]  : inErr;

  assign curHalf = alignHi ? w0Data[INSTR_W-1:HALF_W] : w0Data[HALF_W-1:0];
  assign halfCmp = isCompressed(curHalf);

  always_comb begin
    if (halfCmp) begin
      instr = {{HALF_W{1'b0}}, curHalf};
    end else if (alignHi) begin
      instr = {w1Data[HALF_W-1:0], curHalf};
    end else begin
      instr = w0Data;
    end
  end

  assign err     = w0Err | (alignHi & ~halfCmp & w1Err);
  assign pc      = {w0Addr, alignHi, 1'b0};
  assign headVld = vld[1:0];
  assign lastVld = vld[DEPTH-1];
endmodule

// File: rtl/frf_control.sv
module frf_control
  import frf_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       clearI,
  input  logic       clearHalfSelI,
  input  logic       inValidI,
  input  logic       outReadyI,
  input  logic [1:0] headVld,
  input  logic       lastVld,
  input  logic       halfCmp,
  output frfStrobe_t stb,
  output logic       alignHi,
  output logic       outValid,
  output logic       full
);
  logic accept, avail0, avail1, fire, pop;

  assign full   = lastVld;
  assign accept = inValidI & ~full & ~clearI;
  assign avail0 = headVld[0] | accept;
  assign avail1 = headVld[1] | (headVld[0] & accept);

  assign outValid = ~clearI & ((alignHi & ~halfCmp) ? avail1 : avail0);
  assign fire     = outValid & outReadyI;
  // a word is used up when its upper half has been consumed
  assign pop      = fire & (alignHi | ~halfCmp);

  assign stb.flush = clearI;
  assign stb.shift = pop & headVld[0];
  assign stb.store = accept & ~(pop & ~headVld[0]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      alignHi <= 1'b0;
    end else if (clearI) begin
      alignHi <= clearHalfSelI;
    end else if (fire && halfCmp) begin
      alignHi <= ~alignHi;
    end
  end
endmodule

// File: rtl/fetch_realign_fifo.sv
module fetch_realign_fifo
  import frf_pkg::*;
#(
  parameter int DEPTH  = 3,
  parameter int ADDR_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               clearI,
  input  logic               clearHalfSelI,
  input  logic               inValidI,
  input  logic [INSTR_W-1:0] inDataI,
  input  logic [ADDR_W-3:0]  inWordAddrI,
  input  logic               inErrI,
  output logic               fullO,
  output logic               outValidO,
  input  logic               outReadyI,
  output logic [INSTR_W-1:0] outInstrO,
  output logic [ADDR_W-1:0]  outPcO,
  output logic               outErrO
);
  frfStrobe_t stb;
  logic       alignHi;
  logic [1:0] headVld;
  logic       lastVld;
  logic       halfCmp;

  frf_control ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .clearI       (clearI),
    .clearHalfSelI(clearHalfSelI),
    .inValidI     (inValidI),
    .outReadyI    (outReadyI),
    .headVld      (headVld),
    .lastVld      (lastVld),
    .halfCmp      (halfCmp),
    .stb          (stb),
    .alignHi      (alignHi),
    .outValid     (outValidO),
    .full         (fullO)
  );

  frf_datapath #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .alignHi   (alignHi),
    .inData    (inDataI),
    .inWordAddr(inWordAddrI),
    .inErr     (inErrI),
    .headVld   (headVld),
    .lastVld   (lastVld),
    .instr     (outInstrO),
    .pc        (outPcO),
    .err       (outErrO),
    .halfCmp   (halfCmp)
  );
endmodule

// File: rtl/frf_checker.sv
module frf_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              clearI,
  input logic              fullO,
  input logic              outValidO,
  input logic              outReadyI,
  input logic [31:0]       outInstrO,
  input logic [ADDR_W-1:0] outPcO,
  input logic              outErrO
);
  localparam logic [ADDR_W-1:0] STEP_HALF = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] STEP_WORD = ADDR_W'(4);

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValidO && !outReadyI && !clearI |=> clearI ||
      (outValidO && $stable(outInstrO) && $stable(outPcO) && $stable(outErrO)));

  // R6
  clear_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    clearI |-> !outValidO);

  // R6
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    clearI |=> !fullO);

  // R8
  full_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    fullO && !clearI && !(outValidO && outReadyI) |=> fullO);

  // R4
  pc_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValidO && outReadyI && !clearI |=> clearI || !outValidO ||
      outPcO == $past(outPcO) +
        (($past(outInstrO[1:0]) != 2'b11) ? STEP_HALF : STEP_WORD));

  // R3
  cmp_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValidO && outInstrO[1:0] != 2'b11 |-> outInstrO[31:16] == 16'h0000);

  // R4
  pc_bit0_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValidO |-> !outPcO[0]);
endmodule

bind fetch_realign_fifo frf_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .clearI   (clearI),
  .fullO    (fullO),
  .outValidO(outValidO),
  .outReadyI(outReadyI),
  .outInstrO(outInstrO),
  .outPcO   (outPcO),
  .outErrO  (outErrO)
);

// File: tb/fetch_realign_fifo_tb_top.sv
module fetch_realign_fifo_tb_top;
  localparam int ADDR_W = 32;
  localparam int DEPTH  = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic              clearI = 1'b0, clearHalfSelI = 1'b0;
  logic              inValidI = 1'b0, inErrI = 1'b0;
  logic [31:0]       inDataI = '0;
  logic [ADDR_W-3:0] inWordAddrI = '0;
  logic              fullO, outValidO, outErrO;
  logic              outReadyI = 1'b0;
  logic [31:0]       outInstrO;
  logic [ADDR_W-1:0] outPcO;

  fetch_realign_fifo #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) dut_i (.*);

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  logic [64:0] expQ [$];
  logic [31:0] wData [64];
  logic        wErr [64];

  task automatic check(input bit ok, input string tag, input logic [64:0] act, input logic [64:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] halfAt(input int idx);
    return idx[0] ? wData[idx/2][31:16] : wData[idx/2][15:0];
  endfunction

  task automatic drive(input logic v, input logic [31:0] d, input logic [31:0] byteAddr, input logic e);
    inValidI    = v;
    inDataI     = d;
    inWordAddrI = byteAddr[ADDR_W-1:2];
    inErrI      = e;
  endtask

  task automatic doClear(input logic [31:0] target);
    @(negedge clk);
    clearI = 1'b1;
    clearHalfSelI = target[1];
    drive(1'b0, '0, '0, 1'b0);
    @(negedge clk);
    clearI = 1'b0;
  endtask

  function automatic logic [64:0] packOut();
    return {outErrO, outPcO, outInstrO};
  endfunction

  // Driver side builds the expected list, then feeds words; monitor pops and compares.
  task automatic runStream(input logic [31:0] start, input int n, input int cmpPct,
                           input int errPct, input int gapPct, input int stallPct);
    logic [31:0] base;
    int idx;
    logic [15:0] h, h2;
    base = {start[31:2], 2'b00};
    for (int k = 0; k < n; k++) begin
      logic [15:0] lo, hi;
      lo = 16'($urandom);
      hi = 16'($urandom);
      lo[1:0] = (($urandom % 100) < cmpPct) ? 2'($urandom_range(0, 2)) : 2'b11;
      hi[1:0] = (($urandom % 100) < cmpPct) ? 2'($urandom_range(0, 2)) : 2'b11;
      wData[k] = {hi, lo};
      wErr[k]  = (($urandom % 100) < errPct);
    end
    expQ.delete();
    idx = int'(start[1]);
    while (idx < 2 * n) begin
      h = halfAt(idx);
      if (h[1:0] != 2'b11) begin
        expQ.push_back({wErr[idx/2], base + 32'(2 * idx), 16'h0000, h});
        idx += 1;
      end else if (idx + 1 < 2 * n) begin
        h2 = halfAt(idx + 1);
        expQ.push_back({wErr[idx/2] | wErr[(idx+1)/2], base + 32'(2 * idx), h2, h});
        idx += 2;
      end else begin
        break;
      end
    end
    doClear(start | 32'($urandom % 2));
    fork
      begin : driver
        int k;
        k = 0;
        while (k < n) begin
          @(negedge clk);
          if (!fullO && (($urandom % 100) >= gapPct)) begin
            // bit 0 of the byte address never reaches the block
            drive(1'b1, wData[k], base + 32'(4 * k), wErr[k]);
            k++;
          end else begin
            drive(1'b0, 32'hDEAD_BEEF, '0, 1'b1);
          end
        end
        @(negedge clk);
        drive(1'b0, '0, '0, 1'b0);
      end
      begin : monitor
        int guard;
        logic [64:0] e;
        guard = 0;
        while (expQ.size() > 0 && guard < 4000) begin
          @(negedge clk);
          outReadyI = (($urandom % 100) >= stallPct);
          #2;
          if (outValidO && outReadyI) begin
            e = expQ.pop_front();
            check(packOut() == e, "R10 stream item (R3 R4 R5 R7)", packOut(), e);
          end
          guard++;
        end
        check(expQ.size() == 0, "R10 all items delivered", 65'(expQ.size()), 65'd0);
        outReadyI = 1'b0;
      end
    join
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #2;
    check(!outValidO, "R1 valid after reset", 65'(outValidO), 65'd0);
    check(!fullO, "R1 full after reset", 65'(fullO), 65'd0);

    // bypass, stall hold, full, drop
    doClear(32'h0000_0300);
    outReadyI = 1'b0;
    drive(1'b1, 32'hA0A0_0013, 32'h300, 1'b0);
    #2;
    check(outValidO && outInstrO == 32'hA0A0_0013 && outPcO == 32'h300,
          "R2 same-cycle bypass", packOut(), {1'b0, 32'h300, 32'hA0A0_0013});
    @(negedge clk);
    drive(1'b1, 32'hB1B1_0033, 32'h304, 1'b0);
    #2;
    check(outValidO && outInstrO == 32'hA0A0_0013, "R9 held while stalled",
          packOut(), {1'b0, 32'h300, 32'hA0A0_0013});
    @(negedge clk);
    drive(1'b1, 32'hC2C2_0073, 32'h308, 1'b0);
    @(negedge clk);
    #2;
    check(fullO, "R8 full at DEPTH words", 65'(fullO), 65'd1);
    drive(1'b1, 32'hD3D3_00F3, 32'h30C, 1'b0);
    @(negedge clk);
    drive(1'b0, '0, '0, 1'b0);
    outReadyI = 1'b1;
    #2;
    check(outValidO && outInstrO == 32'hA0A0_0013 && outPcO == 32'h300, "R10 first of three",
          packOut(), {1'b0, 32'h300, 32'hA0A0_0013});
    @(negedge clk);
    #2;
    check(outValidO && outInstrO == 32'hB1B1_0033 && outPcO == 32'h304, "R4 step of four",
          packOut(), {1'b0, 32'h304, 32'hB1B1_0033});
    @(negedge clk);
    #2;
    check(outValidO && outInstrO == 32'hC2C2_0073 && outPcO == 32'h308, "R10 third word",
          packOut(), {1'b0, 32'h308, 32'hC2C2_0073});
    @(negedge clk);
    #2;
    check(!outValidO && !fullO, "R8 word offered while full dropped",
          {63'd0, outValidO, fullO}, 65'd0);

    // clear with coincident word, then compressed pair
    @(negedge clk);
    clearI = 1'b1;
    clearHalfSelI = 1'b0;
    drive(1'b1, 32'h0000_0001, 32'h3FC, 1'b0);
    #2;
    check(!outValidO, "R6 no output during clear", 65'(outValidO), 65'd0);
    @(negedge clk);
    clearI = 1'b0;
    drive(1'b0, '0, '0, 1'b0);
    #2;
    check(!outValidO, "R6 word during clear not stored", 65'(outValidO), 65'd0);
    @(negedge clk);
    drive(1'b1, 32'h5555_0001, 32'h400, 1'b0);
    #2;
    check(outValidO && packOut() == {1'b0, 32'h400, 32'h0000_0001}, "R3 compressed low half",
          packOut(), {1'b0, 32'h400, 32'h0000_0001});
    @(negedge clk);
    drive(1'b0, '0, '0, 1'b0);
    #2;
    check(outValidO && packOut() == {1'b0, 32'h402, 32'h0000_5555}, "R4 step of two",
          packOut(), {1'b0, 32'h402, 32'h0000_5555});
    @(negedge clk);
    #2;
    check(!outValidO, "R10 nothing left", 65'(outValidO), 65'd0);

    // half-word start, 32-bit instruction across two words, error merge
    outReadyI = 1'b0;
    doClear(32'h0000_0502);
    outReadyI = 1'b1;
    drive(1'b1, 32'hABC7_1111, 32'h500, 1'b0);
    #2;
    check(!outValidO, "R5 waits for second word", 65'(outValidO), 65'd0);
    @(negedge clk);
    drive(1'b1, 32'h2222_5678, 32'h504, 1'b1);
    #2;
    check(outValidO && packOut() == {1'b1, 32'h502, 32'h5678_ABC7}, "R5 R7 assembled with error",
          packOut(), {1'b1, 32'h502, 32'h5678_ABC7});
    @(negedge clk);
    drive(1'b0, '0, '0, 1'b0);
    #2;
    check(outValidO && packOut() == {1'b1, 32'h506, 32'h0000_2222}, "R6 R7 upper half after realign",
          packOut(), {1'b1, 32'h506, 32'h0000_2222});
    outReadyI = 1'b0;

    // scoreboard streams
    runStream(32'h0000_1000, 24, 50, 0, 0, 0);
    runStream(32'h0000_2002, 24, 50, 20, 30, 30);
    runStream(32'h0000_3000, 16, 100, 10, 50, 10);
    runStream(32'h0000_4002, 16, 0, 10, 20, 40);
    runStream(32'h0000_5000, 20, 30, 15, 10, 70);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule